// File: doc/BRIEF.md
# SPI Burst Master

This block is a master-only SPI shift engine for a larger chip. Software sets up a small register set through a simple write and read port. It enables the engine, selects one of four slave-select lines, and picks clock polarity, clock phase and bit order. It then loads a byte count and sets a start bit. The engine takes bytes from an internal transmit FIFO and shifts them out on MOSI. At the same time it samples MISO and places each received byte into an internal receive FIFO. When the last byte of the burst has been exchanged, it clears the start bit and emits a one-cycle completion pulse. Software then drains any remaining received bytes.

Chip select normally follows the burst: the selected line goes low while the burst runs. Software can take over the line with an owner bit and then drive it directly with a level bit. If the transmit FIFO runs dry in the middle of a burst, the engine parks SCLK at its idle level and waits for the next byte.

Register map. Every field position below is part of the block's behaviour.
- Address 0, global register: bit 0 enables the engine, bit 1 selects master operation, and writing bit 31 as 1 performs a soft reset.
- Address 1, transfer register: bit 0 is CPHA, bit 1 is CPOL, bits 5:4 select the chip-select line, bit 6 is the owner bit, bit 7 is the level bit, bit 12 selects LSB-first order, and bit 31 is the start bit.
- Address 2: the burst byte count.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, all four chip-select lines are high, SCLK is 0, the transfer register reads 0, the completion pulse is low and both FIFOs are empty.
- R2: When the engine is enabled and the count is non-zero, writing bit 31 of the transfer register as 1 starts a burst. Bit 31 reads 1 while the burst runs. It returns to 0 in the same cycle as a single-cycle pulse on xfer_done.
- R3: A burst exchanges exactly the programmed number of bytes. That is 16 SCLK transitions per byte, and each queued transmit byte is sent once, in FIFO order.
- R4: Bits 5:4 select chip-select line k of cs_n[3:0]. When the owner bit is 0, that line is low only while the burst runs. All other lines stay high.
- R5: When the owner bit (bit 6) is 1, the selected line follows the level bit (bit 7) at all times, with 1 meaning high. This holds whether or not a burst is running.
- R6: When bit 1 (CPOL) is 0, SCLK idles at 0. When it is 1, SCLK idles at 1.
- R7: When bit 0 (CPHA) is 0, MISO is sampled on the first SCLK edge of each bit and MOSI changes on the second. When CPHA is 1, MOSI changes on the first edge and MISO is sampled on the second.
- R8: When bit 12 is 1, each byte is shifted LSB first on both MOSI and MISO. When bit 12 is 0, each byte is shifted MSB first.
- R9: If the transmit FIFO is empty while a burst still has bytes to send, SCLK holds its idle level and bit 31 stays 1. The burst resumes when a byte is pushed.
- R10: A start request is ignored unless both the enable bit (bit 0) and the master bit (bit 1) of the global register are 1.
- R11: Writing bit 31 of the global register as 1 aborts any burst and empties both FIFOs. It also clears the transfer register and the count. Bits 1:0 of the same write are loaded.
- R12: Received bytes appear on rx_byte in arrival order. Each rx_pop removes one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 global, 1 transfer, 2 count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the addressed register |
| tx_push | input | 1 | Push tx_byte into the transmit FIFO |
| tx_byte | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_byte | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| xfer_done | output | 1 | One-cycle pulse when a burst ends |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Master data in |
| cs_n | output | 4 | Slave-select lines |

## Verification
Some behaviours are checked on every cycle by the bound assertions:
- SCLK sits at the idle level given by CPOL whenever no burst runs and while the engine waits on an empty transmit FIFO.
- At most one chip-select line is ever low.
- Hardware-owned chip select is released outside bursts.
- The completion pulse lasts one cycle and coincides with the start bit being clear.

Other behaviours can only be shown by the bench's scenarios, using a slave model that follows each phase, polarity and bit-order combination:
- that the correct data bits are exchanged in each mode,
- that bytes are counted correctly,
- that received bytes land in the FIFO in order,
- that the stall, software override, disable and soft-reset sequences behave as required.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int FIFO_DEPTH = 8,   // power of two
  parameter int HALF_DIV   = 2,   // clk cycles per SCLK half period, >= 2
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_push,
  input  logic [7:0]  tx_byte,
  output logic        tx_full,
  output logic        tx_empty,
  input  logic        rx_pop,
  output logic [7:0]  rx_byte,
  output logic        rx_empty,
  output logic        xfer_done,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int DW = $clog2(HALF_DIV);
  localparam int NCS = 4;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(FIFO_DEPTH);
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} st_t;

  st_t st;
  logic g_en, g_master;
  logic cfg_cpha, cfg_cpol, cfg_lsb, cfg_owner, cfg_level;
  logic [1:0] cfg_cs;
  logic busy, done_q;
  logic [CNT_W-1:0] burst_left;
  logic [DW-1:0] hcnt;
  logic [3:0] ph;
  logic sclk_q, mosi_q;
  logic [7:0] tsh, rsh;

  logic [7:0] tx_mem [FIFO_DEPTH];
  logic [7:0] rx_mem [FIFO_DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0] tx_cnt, rx_cnt;

  wire unused_wdata = ^reg_wdata;

  function automatic logic first_bit(input logic lsb, input logic [7:0] b);
    return lsb ? b[0] : b[7];
  endfunction

  function automatic logic [7:0] advance(input logic lsb, input logic [7:0] b);
    return lsb ? {1'b0, b[7:1]} : {b[6:0], 1'b0};
  endfunction

  wire srst   = reg_wr && reg_addr == 2'd0 && reg_wdata[31];
  wire wr_tc  = reg_wr && reg_addr == 2'd1;
  wire wr_cnt = reg_wr && reg_addr == 2'd2;
  wire start_req = wr_tc && reg_wdata[31] && !busy && g_en && g_master
                   && burst_left != '0;

  wire in_load   = (st == S_LOAD);
  wire tx_pop_e  = in_load && tx_cnt != '0;
  wire edge_tick = (st == S_SHIFT) && hcnt == DIV_LAST;
  wire lead      = edge_tick && !ph[0];
  wire trail     = edge_tick && ph[0];
  wire samp      = cfg_cpha ? trail : lead;
  wire drive     = cfg_cpha ? lead : (trail && ph != 4'd15);
  wire last      = trail && ph == 4'd15;
  wire [7:0] rsh_nxt = cfg_lsb ? {miso, rsh[7:1]} : {rsh[6:0], miso};
  wire [7:0] rx_in   = samp ? rsh_nxt : rsh;
  wire rx_push_e = last && rx_cnt != FULL_LVL;
  wire tx_push_e = tx_push && tx_cnt != FULL_LVL;
  wire rx_pop_e  = rx_pop && rx_cnt != '0;
  wire [7:0] tx_head = tx_mem[tx_rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; g_en <= 1'b0; g_master <= 1'b0;
      cfg_cpha <= 1'b0; cfg_cpol <= 1'b0; cfg_lsb <= 1'b0;
      cfg_owner <= 1'b0; cfg_level <= 1'b0; cfg_cs <= 2'd0;
      busy <= 1'b0; done_q <= 1'b0; burst_left <= '0;
      hcnt <= '0; ph <= '0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      tsh <= '0; rsh <= '0;
    end else if (srst) begin
      st <= S_IDLE; g_en <= reg_wdata[0]; g_master <= reg_wdata[1];
      cfg_cpha <= 1'b0; cfg_cpol <= 1'b0; cfg_lsb <= 1'b0;
      cfg_owner <= 1'b0; cfg_level <= 1'b0; cfg_cs <= 2'd0;
      busy <= 1'b0; done_q <= 1'b0; burst_left <= '0;
      hcnt <= '0; ph <= '0; sclk_q <= 1'b0; mosi_q <= 1'b0;
      tsh <= '0; rsh <= '0;
    end else begin
      done_q <= 1'b0;
      if (reg_wr && reg_addr == 2'd0) begin
        g_en <= reg_wdata[0];
        g_master <= reg_wdata[1];
      end
      if (wr_tc && !busy) begin
        cfg_cpha <= reg_wdata[0]; cfg_cpol <= reg_wdata[1];
        cfg_cs <= reg_wdata[5:4]; cfg_owner <= reg_wdata[6];
        cfg_level <= reg_wdata[7]; cfg_lsb <= reg_wdata[12];
      end
      if (wr_cnt && !busy) burst_left <= reg_wdata[CNT_W-1:0];
      case (st)
        S_IDLE: if (start_req) begin
          busy <= 1'b1;
          st <= S_LOAD;
        end
        S_LOAD: if (tx_pop_e) begin
          if (cfg_cpha) tsh <= tx_head;
          else begin
            mosi_q <= first_bit(cfg_lsb, tx_head);
            tsh <= advance(cfg_lsb, tx_head);
          end
          hcnt <= '0;
          ph <= '0;
          st <= S_SHIFT;
        end
        S_SHIFT: begin
          hcnt <= edge_tick ? '0 : hcnt + 1'b1;
          if (edge_tick) begin
            sclk_q <= ~sclk_q;
            ph <= ph + 4'd1;
          end
          if (samp) rsh <= rsh_nxt;
          if (drive) begin
            mosi_q <= first_bit(cfg_lsb, tsh);
            tsh <= advance(cfg_lsb, tsh);
          end
          if (last) begin
            burst_left <= burst_left - 1'b1;
            if (burst_left == CNT_W'(1)) begin
              st <= S_IDLE;
              busy <= 1'b0;
              done_q <= 1'b1;
            end else begin
              st <= S_LOAD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push_e) tx_wp <= tx_wp + 1'b1;
      if (tx_pop_e)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (AW+1)'(tx_push_e) - (AW+1)'(tx_pop_e);
      if (rx_push_e) rx_wp <= rx_wp + 1'b1;
      if (rx_pop_e)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (AW+1)'(rx_push_e) - (AW+1)'(rx_pop_e);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push_e) tx_mem[tx_wp] <= tx_byte;
    if (rx_push_e) rx_mem[rx_wp] <= rx_in;
  end

  assign tx_full   = tx_cnt == FULL_LVL;
  assign tx_empty  = tx_cnt == '0;
  assign rx_empty  = rx_cnt == '0;
  assign rx_byte   = rx_mem[rx_rp];
  assign xfer_done = done_q;
  assign sclk      = sclk_q ^ cfg_cpol;
  assign mosi      = mosi_q;

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_n[k] = (cfg_cs == 2'(k)) ? (cfg_owner ? cfg_level : !busy) : 1'b1;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'd0, g_master, g_en};
      2'd1:    reg_rdata = {busy, 18'd0, cfg_lsb, 4'd0, cfg_level, cfg_owner,
                            cfg_cs, 2'd0, cfg_cpol, cfg_cpha};
      2'd2:    reg_rdata = 32'(burst_left);
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic [3:0] cs_n,
  input logic       busy,
  input logic       cpol,
  input logic       owner,
  input logic       loading,
  input logic       done
);
  a_r6_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);
  a_r9_stall_parks_clock: assert property (@(posedge clk) disable iff (!rst_n)
    loading |-> sclk == cpol);
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r4_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !owner) |-> cs_n == 4'hF);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .busy(busy),
  .cpol(cfg_cpol), .owner(cfg_owner), .loading(in_load), .done(xfer_done)
);

// File: tb/tb_spi_burst_master.sv
module tb_spi_burst_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0; logic [1:0] reg_addr = 2'd0; logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tx_push = 1'b0; logic [7:0] tx_byte = '0;
  logic tx_full, tx_empty, rx_empty, xfer_done, sclk, mosi;
  logic rx_pop = 1'b0; logic [7:0] rx_byte;
  logic miso_r = 1'b0; logic [3:0] cs_n;

  always #10 clk = ~clk;

  spi_burst_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
    .tx_byte(tx_byte), .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
    .rx_byte(rx_byte), .rx_empty(rx_empty), .xfer_done(xfer_done), .sclk(sclk),
    .mosi(mosi), .miso(miso_r), .cs_n(cs_n));

  int vectors = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_mosi[$], miso_q[$], exp_rx[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave model and mosi monitor
  bit sl_on = 0, sl_cpol = 0, sl_cpha = 0, sl_lsb = 0;
  int edges = 0, bi = 0;
  logic [7:0] sb = '0, cap = '0;

  function automatic logic bitof(input logic [7:0] b, input int i, input bit lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  always @(sclk) if (sl_on) begin
    edges++;
    if ((sclk != sl_cpol) ^ sl_cpha) begin
      if (sl_lsb) cap[bi] = mosi; else cap[7-bi] = mosi;
      bi++;
      if (bi == 8) begin
        bi = 0;
        if (exp_mosi.size() == 0) chk(0, "R3 extra mosi byte", cap, 0);
        else begin
          logic [7:0] e;
          e = exp_mosi.pop_front();
          chk(cap == e, "R7 R8 mosi byte", cap, e);
        end
        sb = (miso_q.size() != 0) ? miso_q.pop_front() : 8'h00;
      end
    end else begin
      miso_r = bitof(sb, bi, sl_lsb);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_push = 1'b1; tx_byte = b;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic xfer(input bit cpol, input bit cpha, input bit lsb, input logic [1:0] cs,
                      input bit own, input bit lvl, input int n, input int hold, input logic [7:0] seed);
    logic [31:0] cfg, v;
    logic [3:0] cs_busy, cs_after;
    bit got;
    exp_mosi.delete(); miso_q.delete(); exp_rx.delete();
    for (int i = 0; i < n; i++) begin
      logic [7:0] t, r;
      t = seed + 8'(i * 37);
      r = ~seed ^ 8'(i * 11);
      exp_mosi.push_back(t); miso_q.push_back(r); exp_rx.push_back(r);
      if (i < hold) push_tx(t);
    end
    sl_on = 0; sl_cpol = cpol; sl_cpha = cpha; sl_lsb = lsb;
    cfg = {19'd0, lsb, 4'd0, lvl, own, cs, 2'd0, cpol, cpha};
    wr(2'd2, 32'(n));
    wr(2'd1, cfg);
    chk(sclk == cpol, "R6 idle sclk", 32'(sclk), 32'(cpol));
    sb = miso_q.pop_front(); bi = 0; edges = 0;
    miso_r = cpha ? 1'b0 : bitof(sb, 0, lsb);
    sl_on = 1;
    wr(2'd1, cfg | 32'h8000_0000);
    cs_busy = 4'hF; cs_after = 4'hF;
    if (own) begin cs_busy[cs] = lvl; cs_after[cs] = lvl; end
    else cs_busy[cs] = 1'b0;
    rd(2'd1, v);
    chk(v[31] == 1'b1, "R2 start reads 1", v, cfg | 32'h8000_0000);
    chk(cs_n == cs_busy, own ? "R5 cs override busy" : "R4 cs during burst", cs_n, cs_busy);
    if (hold < n) begin
      repeat (150) @(negedge clk);
      chk(edges == 16 * hold, "R9 no edges while starved", edges, 16 * hold);
      chk(sclk == cpol, "R9 sclk parked", sclk, cpol);
      rd(2'd1, v);
      chk(v[31] == 1'b1, "R9 start held", v[31], 1);
      for (int i = hold; i < n; i++) push_tx(seed + 8'(i * 37));
    end
    got = 0;
    for (int c = 0; c < 5000 && !got; c++) begin
      @(negedge clk);
      if (xfer_done) got = 1;
    end
    chk(got, "R2 done pulse", got, 1);
    rd(2'd1, v);
    chk(v == cfg, "R2 start cleared", v, cfg);
    chk(edges == 16 * n, "R3 sclk edge count", edges, 16 * n);
    chk(exp_mosi.size() == 0, "R3 all bytes sent", exp_mosi.size(), 0);
    chk(cs_n == cs_after, own ? "R5 cs override idle" : "R4 cs released", cs_n, cs_after);
    sl_on = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      chk(!rx_empty && rx_byte == e, "R12 R7 R8 rx byte", rx_byte, e);
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
    end
    chk(rx_empty, "R12 rx drained", rx_empty, 1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v);
    chk(v == 0, "R1 transfer reg", v, 0);
    chk(cs_n == 4'hF, "R1 cs lines", cs_n, 4'hF);
    chk(sclk == 0 && !xfer_done, "R1 sclk and done", {sclk, xfer_done}, 0);
    chk(rx_empty && tx_empty, "R1 fifos empty", {rx_empty, tx_empty}, 2'b11);

    // R10: engine disabled, start ignored
    wr(2'd0, 32'h1);
    wr(2'd2, 32'd1);
    push_tx(8'hA5);
    edges = 0; sl_cpol = 0; sl_on = 1;
    wr(2'd1, 32'h8000_0000);
    repeat (60) @(negedge clk);
    rd(2'd1, v);
    chk(v[31] == 0, "R10 start ignored", v, 0);
    chk(edges == 0 && cs_n == 4'hF, "R10 no activity", {edges[27:0], cs_n}, 32'hF);
    sl_on = 0;
    wr(2'd0, 32'h8000_0003);
    chk(tx_empty, "R11 flush clears tx", tx_empty, 1);

    xfer(0, 0, 0, 2'd0, 0, 0, 3, 3, 8'h3C);
    xfer(1, 0, 0, 2'd1, 0, 0, 2, 2, 8'h96);
    xfer(0, 1, 0, 2'd2, 0, 0, 4, 4, 8'h5A);
    xfer(1, 1, 0, 2'd3, 0, 0, 1, 1, 8'hE1);
    xfer(0, 0, 1, 2'd1, 0, 0, 5, 5, 8'h17);
    xfer(1, 1, 1, 2'd0, 0, 0, 8, 8, 8'hC3);
    xfer(0, 1, 1, 2'd2, 1, 1, 2, 2, 8'h81);
    xfer(1, 0, 0, 2'd3, 1, 0, 2, 2, 8'h42);
    xfer(1, 0, 1, 2'd1, 0, 0, 3, 1, 8'h6D);

    // R11: soft reset aborts a running burst
    for (int i = 0; i < 4; i++) push_tx(8'(i + 1));
    wr(2'd2, 32'd4);
    wr(2'd1, 32'h8000_0012);
    repeat (30) @(negedge clk);
    wr(2'd0, 32'h8000_0003);
    rd(2'd1, v);
    chk(v == 0, "R11 transfer reg cleared", v, 0);
    rd(2'd2, v);
    chk(v == 0, "R11 count cleared", v, 0);
    rd(2'd0, v);
    chk(v == 3, "R11 enable bits loaded", v, 3);
    chk(cs_n == 4'hF && sclk == 0, "R11 lines idle", {cs_n, sclk}, 5'h1E);
    chk(rx_empty && tx_empty, "R11 fifos emptied", {rx_empty, tx_empty}, 2'b11);
    repeat (40) @(negedge clk);
    chk(!xfer_done && cs_n == 4'hF, "R11 stays aborted", {xfer_done, cs_n}, 5'h0F);

    xfer(0, 1, 0, 2'd0, 0, 0, 2, 2, 8'hB4);
    summary();
  end
endmodule